// File: doc/BRIEF.md
# Paged Audio Controller Register Window

This block is the register window of a three-channel audio controller. The channels are playback 1, playback 2 and capture. A 64-byte window is reached through a plain valid/ready register port that accepts byte, 16-bit and 32-bit reads and writes. Narrow write data sits in the low bits of the write bus and is placed into the addressed byte lanes of the target register. Narrow read data comes back in the low bits.

The window holds a control word, a read-only status word, a serial/channel control word, a codec word, three sample-count words and a small page register. The top 16 bytes of the window are not stored locally. Any access there is forwarded to a paged region, with the page register supplying the upper address bits.

Each channel has a pending flag. A pulse on the channel's `set_pend` input raises the flag, but only while the channel's interrupt enable is set. Turning that enable off through a serial-control write drops the flag. The status word shows the flags together with a summary bit, and the interrupt output is the OR of the flags. The block also reports which channels are active.

Top module: `aud_regwin`

## Requirements
- R1: A synchronous active-low reset clears every register: control, serial control, codec, counts, page and pending flags. After reset, `irq` and `chan_act` are 0 and every local register reads 0.
- R2: Word writes to control (0x00), codec (0x10), serial control (0x20) and the counts (0x24, 0x28, 0x2C) read back unchanged. A write to the page register (0x0C) keeps only the low 4 bits of the write data.
- R3: Size encoding is 0 for byte, 1 for half and 2 for word.
  - A byte write replaces only lane `addr[1:0]`, taking its data from `wdata[7:0]`.
  - A half write at lane 0 or 2 replaces that half, taking its data from `wdata[15:0]`.
  - Misaligned half or word accesses change nothing and read 0.
- R4: A narrow read returns the addressed byte or half in the low bits, with the upper bits zero. This includes byte reads of status.
- R5: A pulse on `set_pend[i]` sets the channel's pending flag only while interrupt enable bit 8+i of serial control is 1. Flags stay set until they are cleared.
  - Channel 0 (playback 1) shows in status bit 2.
  - Channel 1 (playback 2) shows in status bit 1.
  - Channel 2 (capture) shows in status bit 0.
- R6: Status bit 31 and `irq` are both 1 exactly when any pending flag is set.
- R7: A serial-control write that changes an interrupt enable bit from 1 to 0 clears that channel's pending flag. Writes that leave an enable at 1, or keep it at 0, clear nothing.
- R8: `chan_act[i]` is 1 when the control enable bit is set and the channel's pause bit in serial control is clear.
  - The control enable bits are 6, 5 and 4 for channels 0, 1 and 2.
  - The pause bits are 11 for channel 0 and 12 for channel 1. Capture has no pause bit.
- R9: Accesses at offsets 0x30 to 0x3F go to the paged region and store nothing locally.
  - They assert `fwd_valid` in the same cycle, with `fwd_addr` equal to the offset ORed with the page value shifted left by 8.
  - Their read response returns `fwd_rdata`.
- R10: Writes to status and to unmapped offsets have no effect, and reads of unmapped offsets return 0.
- R11: Every read is answered with `rsp_valid` high for exactly one cycle, in the cycle after the request. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half, 2 word |
| req_addr | input | 6 | Byte offset in window |
| req_wdata | input | 32 | Write data, low-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, low-aligned |
| set_pend | input | 3 | Per-channel pending set pulses |
| irq | output | 1 | Level interrupt |
| chan_act | output | 3 | Per-channel active flags |
| fwd_valid | output | 1 | Paged access present |
| fwd_write | output | 1 | Paged access is a write |
| fwd_size | output | 2 | Paged access size |
| fwd_addr | output | 12 | Effective paged address |
| fwd_wdata | output | 32 | Paged write data |
| fwd_rdata | input | 32 | Paged read data, same cycle |

## Verification
The assertions rely on a few properties of the inputs. `set_pend` is the only thing that can raise a flag, and a register write is the only thing that can change `chan_act` or lower `irq`. Both reset and `set_pend` are kept apart from the cycles being judged. The bench therefore pulses `set_pend` only between register accesses and never while reset is active. It holds reset for several cycles, so that all outputs have settled before the checks are enabled again. Paged read data is driven by the bench in the same cycle as the request, because the block takes `fwd_rdata` combinationally.

// File: rtl/aud_regwin_pkg.sv
package aud_regwin_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned NLANE  = DATA_W / 8;
    localparam int unsigned NCH    = 3;
    localparam int unsigned SUM_BIT = 31;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    localparam logic [5:0] OFF_CTL   = 6'h00;
    localparam logic [5:0] OFF_STAT  = 6'h04;
    localparam logic [5:0] OFF_PAGE  = 6'h0C;
    localparam logic [5:0] OFF_CODEC = 6'h10;
    localparam logic [5:0] OFF_SCTL  = 6'h20;
    localparam logic [5:0] OFF_CNT0  = 6'h24;
    localparam logic [5:0] OFF_CNT1  = 6'h28;
    localparam logic [5:0] OFF_CNT2  = 6'h2C;
    localparam logic [5:0] OFF_PAGED = 6'h30;

    // channel 0 = playback 1, 1 = playback 2, 2 = capture
    function automatic int en_bit(int ch);
        return 6 - ch;
    endfunction

    function automatic int ien_bit(int ch);
        return 8 + ch;
    endfunction

    function automatic int pnd_bit(int ch);
        return 2 - ch;
    endfunction

    function automatic int pause_bit(int ch);
        return 11 + ch;
    endfunction

    function automatic bit has_pause(int ch);
        return ch < 2;
    endfunction

endpackage

// File: rtl/aud_addr_decode.sv
module aud_addr_decode
    import aud_regwin_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned PAGE_W = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          size,
    input  logic [PAGE_W-1:0]   page,
    output logic                paged,
    output logic                aligned,
    output logic [ADDR_W-1:0]   base,
    output logic [1:0]          lane,
    output logic [NLANE-1:0]    bmask,
    output logic [PAGE_W+7:0]   eaddr
);

    localparam int unsigned EA_W = PAGE_W + 8;

    always_comb begin
        lane  = addr[1:0];
        base  = {addr[ADDR_W-1:2], 2'b00};
        paged = (addr >= ADDR_W'(OFF_PAGED));
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                aligned = 1'b1;
                bmask   = NLANE'(4'b0001 << lane);
            end
            SZ_HALF: begin
                aligned = ~lane[0];
                bmask   = NLANE'(4'b0011 << lane);
            end
            SZ_WORD: begin
                aligned = (lane == 2'd0);
                bmask   = '1;
            end
            default: begin
                aligned = 1'b0;
                bmask   = '0;
            end
        endcase
        if (!aligned) begin
            bmask = '0;
        end
        eaddr = EA_W'(addr);
        if (paged) begin
            eaddr = eaddr | {page, 8'h00};
        end
    end

endmodule

// File: rtl/aud_pend_ctrl.sv
module aud_pend_ctrl #(
    parameter int unsigned NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_pend,
    input  logic [NCH-1:0] ien_q,
    input  logic [NCH-1:0] ien_d,
    output logic [NCH-1:0] pend_q
);

    logic [NCH-1:0] pend_d;

    // per channel: set gated by current enable, clear on enable 1->0
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_comb begin
            pend_d[c] = pend_q[c] | (set_pend[c] & ien_q[c]);
            if (ien_q[c] && !ien_d[c]) begin
                pend_d[c] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/aud_regwin.sv
module aud_regwin
    import aud_regwin_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned PAGE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic [NCH-1:0]      set_pend,
    output logic                irq,
    output logic [NCH-1:0]      chan_act,
    output logic                fwd_valid,
    output logic                fwd_write,
    output logic [1:0]          fwd_size,
    output logic [PAGE_W+7:0]   fwd_addr,
    output logic [DATA_W-1:0]   fwd_wdata,
    input  logic [DATA_W-1:0]   fwd_rdata
);

    typedef struct packed {
        logic [DATA_W-1:0]           ctl;
        logic [DATA_W-1:0]           sctl;
        logic [DATA_W-1:0]           codec;
        logic [NCH-1:0][DATA_W-1:0]  cnt;
        logic [PAGE_W-1:0]           page;
        logic                        rsp_v;
        logic [DATA_W-1:0]           rsp_d;
    } state_t;

    state_t s_d, s_q;

    logic              paged, aligned;
    logic [ADDR_W-1:0] base;
    logic [1:0]        lane;
    logic [NLANE-1:0]  bmask;
    logic [PAGE_W+7:0] eaddr;
    logic [DATA_W-1:0] wmask, wshift, stat_w, sel_w, size_m;
    logic [NCH-1:0]    ien_q, ien_d, pend_q;
    logic              do_wr, do_rd;

    aud_addr_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dec (
        .addr    (req_addr),
        .size    (req_size),
        .page    (s_q.page),
        .paged   (paged),
        .aligned (aligned),
        .base    (base),
        .lane    (lane),
        .bmask   (bmask),
        .eaddr   (eaddr)
    );

    aud_pend_ctrl #(.NCH(NCH)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_pend (set_pend),
        .ien_q    (ien_q),
        .ien_d    (ien_d),
        .pend_q   (pend_q)
    );

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        assign wmask[8*k +: 8] = {8{bmask[k]}};
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign ien_q[c] = s_q.sctl[ien_bit(c)];
        assign ien_d[c] = s_d.sctl[ien_bit(c)];
        if (has_pause(c)) begin : g_pz
            assign chan_act[c] = s_q.ctl[en_bit(c)] & ~s_q.sctl[pause_bit(c)];
        end else begin : g_npz
            assign chan_act[c] = s_q.ctl[en_bit(c)];
        end
    end

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                                input logic [DATA_W-1:0] nv,
                                                input logic [DATA_W-1:0] m);
        return (old & ~m) | (nv & m);
    endfunction

    assign wshift = req_wdata << {lane, 3'b000};
    assign do_wr  = req_valid & req_write & ~paged;
    assign do_rd  = req_valid & ~req_write;

    always_comb begin
        stat_w = '0;
        for (int c = 0; c < NCH; c++) begin
            stat_w[pnd_bit(c)] = pend_q[c];
        end
        stat_w[SUM_BIT] = |pend_q;

        unique case (acc_size_e'(req_size))
            SZ_BYTE: size_m = DATA_W'(8'hFF);
            SZ_HALF: size_m = DATA_W'(16'hFFFF);
            default: size_m = '1;
        endcase

        sel_w = '0;
        case (base)
            ADDR_W'(OFF_CTL):   sel_w = s_q.ctl;
            ADDR_W'(OFF_STAT):  sel_w = stat_w;
            ADDR_W'(OFF_PAGE):  sel_w = DATA_W'(s_q.page);
            ADDR_W'(OFF_CODEC): sel_w = s_q.codec;
            ADDR_W'(OFF_SCTL):  sel_w = s_q.sctl;
            ADDR_W'(OFF_CNT0):  sel_w = s_q.cnt[0];
            ADDR_W'(OFF_CNT1):  sel_w = s_q.cnt[1];
            ADDR_W'(OFF_CNT2):  sel_w = s_q.cnt[2];
            default:            sel_w = '0;
        endcase

        s_d       = s_q;
        s_d.rsp_v = do_rd;
        s_d.rsp_d = '0;

        if (do_wr) begin
            case (base)
                ADDR_W'(OFF_CTL):   s_d.ctl    = merge(s_q.ctl, wshift, wmask);
                ADDR_W'(OFF_CODEC): s_d.codec  = merge(s_q.codec, wshift, wmask);
                ADDR_W'(OFF_SCTL):  s_d.sctl   = merge(s_q.sctl, wshift, wmask);
                ADDR_W'(OFF_CNT0):  s_d.cnt[0] = merge(s_q.cnt[0], wshift, wmask);
                ADDR_W'(OFF_CNT1):  s_d.cnt[1] = merge(s_q.cnt[1], wshift, wmask);
                ADDR_W'(OFF_CNT2):  s_d.cnt[2] = merge(s_q.cnt[2], wshift, wmask);
                ADDR_W'(OFF_PAGE): begin
                    if (bmask[0]) begin
                        s_d.page = req_wdata[PAGE_W-1:0];
                    end
                end
                default: ;
            endcase
        end

        if (do_rd) begin
            if (paged) begin
                s_d.rsp_d = fwd_rdata;
            end else if (aligned) begin
                s_d.rsp_d = (sel_w >> {lane, 3'b000}) & size_m;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = 1'b1;
    assign rsp_valid = s_q.rsp_v;
    assign rsp_rdata = s_q.rsp_d;
    assign irq       = |pend_q;
    assign fwd_valid = req_valid & paged;
    assign fwd_write = req_write;
    assign fwd_size  = req_size;
    assign fwd_addr  = eaddr;
    assign fwd_wdata = req_wdata;

endmodule

// File: rtl/aud_regwin_chk.sv
module aud_regwin_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned PAGE_W = 4,
    parameter int unsigned NCH    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [NCH-1:0]    set_pend,
    input logic              irq,
    input logic [NCH-1:0]    chan_act,
    input logic              rsp_valid,
    input logic              fwd_valid,
    input logic [PAGE_W+7:0] fwd_addr
);

    logic seen;
    always_ff @(posedge clk) begin
        seen <= 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!seen)
        (rst_n && $past(!rst_n)) |-> (!irq && chan_act == '0 && !rsp_valid));

    assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $rose(irq) |-> $past(|set_pend));

    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $fell(irq) |-> $past(req_valid && req_write));

    assert_act_change_R8: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        !$stable(chan_act) |-> $past(req_valid && req_write));

    assert_fwd_addr_R9: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        fwd_valid |-> (req_valid && fwd_addr[ADDR_W-1:0] == req_addr));

    assert_rd_resp_R11: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (req_valid && !req_write) |=> rsp_valid);

    assert_no_resp_R11: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        !(req_valid && !req_write) |=> !rsp_valid);

endmodule

bind aud_regwin aud_regwin_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NCH(aud_regwin_pkg::NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .set_pend  (set_pend),
    .irq       (irq),
    .chan_act  (chan_act),
    .rsp_valid (rsp_valid),
    .fwd_valid (fwd_valid),
    .fwd_addr  (fwd_addr)
);

// File: tb/aud_regwin_tb.sv
module aud_regwin_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0, fwd_rdata = '0;
    logic [2:0]  set_pend = '0;
    logic        req_ready, rsp_valid, irq, fwd_valid, fwd_write;
    logic [31:0] rsp_rdata, fwd_wdata;
    logic [2:0]  chan_act;
    logic [1:0]  fwd_size;
    logic [11:0] fwd_addr;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    aud_regwin u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .set_pend(set_pend), .irq(irq), .chan_act(chan_act), .fwd_valid(fwd_valid),
        .fwd_write(fwd_write), .fwd_size(fwd_size), .fwd_addr(fwd_addr),
        .fwd_wdata(fwd_wdata), .fwd_rdata(fwd_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd2, 6'h00, 32'h0,        32'h0,        4'd1},  // R1 ctl after reset
        '{1'b0, 2'd2, 6'h20, 32'h0,        32'h0,        4'd1},  // R1 sctl
        '{1'b0, 2'd2, 6'h0C, 32'h0,        32'h0,        4'd1},  // R1 page
        '{1'b1, 2'd2, 6'h00, 32'h12345678, 32'h0,        4'd2},  // R2
        '{1'b0, 2'd2, 6'h00, 32'h0,        32'h12345678, 4'd2},
        '{1'b1, 2'd0, 6'h01, 32'h000000AB, 32'h0,        4'd3},  // R3 byte lane 1
        '{1'b0, 2'd2, 6'h00, 32'h0,        32'h1234AB78, 4'd3},
        '{1'b1, 2'd1, 6'h02, 32'h0000BEEF, 32'h0,        4'd3},  // R3 upper half
        '{1'b0, 2'd2, 6'h00, 32'h0,        32'hBEEFAB78, 4'd3},
        '{1'b1, 2'd1, 6'h01, 32'h0000FFFF, 32'h0,        4'd3},  // R3 misaligned
        '{1'b0, 2'd2, 6'h00, 32'h0,        32'hBEEFAB78, 4'd3},
        '{1'b0, 2'd0, 6'h03, 32'h0,        32'h000000BE, 4'd4},  // R4
        '{1'b0, 2'd1, 6'h02, 32'h0,        32'h0000BEEF, 4'd4},
        '{1'b0, 2'd0, 6'h00, 32'h0,        32'h00000078, 4'd4},
        '{1'b0, 2'd2, 6'h02, 32'h0,        32'h0,        4'd3},  // R3 misaligned read
        '{1'b1, 2'd2, 6'h0C, 32'hFFFFFFF7, 32'h0,        4'd2},  // R2 page low 4
        '{1'b0, 2'd2, 6'h0C, 32'h0,        32'h00000007, 4'd2},
        '{1'b1, 2'd2, 6'h10, 32'hCAFE0001, 32'h0,        4'd2},
        '{1'b0, 2'd2, 6'h10, 32'h0,        32'hCAFE0001, 4'd2},
        '{1'b1, 2'd2, 6'h2C, 32'h00010203, 32'h0,        4'd2},
        '{1'b0, 2'd2, 6'h2C, 32'h0,        32'h00010203, 4'd2},
        '{1'b1, 2'd2, 6'h14, 32'hFFFFFFFF, 32'h0,        4'd10}, // R10 unmapped
        '{1'b0, 2'd2, 6'h14, 32'h0,        32'h0,        4'd10},
        '{1'b1, 2'd2, 6'h04, 32'hFFFFFFFF, 32'h0,        4'd10}, // R10 status write
        '{1'b0, 2'd2, 6'h04, 32'h0,        32'h0,        4'd10},
        '{1'b1, 2'd0, 6'h22, 32'h000000FF, 32'h0,        4'd3},  // R3 sctl byte 2
        '{1'b0, 2'd2, 6'h20, 32'h0,        32'h00FF0000, 4'd3}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [1:0] sz, input logic [5:0] a,
                       input logic [31:0] d, output logic [31:0] rd, output logic rv);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd = rsp_rdata; rv = rsp_valid;
    endtask

    task automatic wr(input logic [1:0] sz, input logic [5:0] a, input logic [31:0] d);
        logic [31:0] r; logic v;
        acc(1'b1, sz, a, d, r, v);
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] sz, input logic [5:0] a,
                          input logic [31:0] exp);
        logic [31:0] r; logic v;
        acc(1'b0, sz, a, 32'h0, r, v);
        check(tag, r, exp);
    endtask

    task automatic pulse(input logic [2:0] p);
        @(negedge clk); set_pend = p;
        @(negedge clk); set_pend = '0;
    endtask

    task automatic probe(input string tag, input logic w, input logic [5:0] a,
                         input logic ev, input logic [11:0] ea);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_size = 2'd2; req_addr = a; req_wdata = 32'h11223344;
        #1;
        check(tag, {31'b0, fwd_valid}, {31'b0, ev});
        if (ev) check(tag, {20'b0, fwd_addr}, {20'b0, ea});
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r; logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 chan_act", {29'b0, chan_act}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            acc(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].data, r, v);
            if (!VECS[i].wr) check($sformatf("R%0d vec%0d", VECS[i].req, i), r, VECS[i].exp);
        end

        // R8 active flags; ctl byte0 = 0x78
        wr(2'd2, 6'h20, 32'h0);
        check("R8 all on", {29'b0, chan_act}, 32'h7);
        wr(2'd2, 6'h20, 32'h00000800);
        check("R8 pause p1", {29'b0, chan_act}, 32'h6);
        wr(2'd2, 6'h20, 32'h00001000);
        check("R8 pause p2", {29'b0, chan_act}, 32'h5);
        wr(2'd0, 6'h00, 32'h00000060);
        check("R8 cap disabled", {29'b0, chan_act}, 32'h1);
        wr(2'd2, 6'h20, 32'h0);
        check("R8 unpause", {29'b0, chan_act}, 32'h3);

        // R5 gating and R6 summary
        pulse(3'b111);
        rd_chk("R5 gated off", 2'd2, 6'h04, 32'h0);
        wr(2'd2, 6'h20, 32'h00000700);
        pulse(3'b010);
        rd_chk("R5 p2 pending", 2'd2, 6'h04, 32'h80000002);
        check("R6 irq high", {31'b0, irq}, 32'h1);
        pulse(3'b001);
        rd_chk("R5 p1 pending", 2'd2, 6'h04, 32'h80000006);
        rd_chk("R4 R6 status byte3", 2'd0, 6'h07, 32'h00000080);
        rd_chk("R4 status byte0", 2'd0, 6'h04, 32'h00000006);

        // R7 clear on enable falling
        wr(2'd2, 6'h20, 32'h00000600);
        rd_chk("R7 p1 cleared", 2'd2, 6'h04, 32'h80000002);
        wr(2'd2, 6'h20, 32'h00000600);
        rd_chk("R7 no spurious clear", 2'd2, 6'h04, 32'h80000002);
        pulse(3'b001);
        rd_chk("R5 p1 disabled", 2'd2, 6'h04, 32'h80000002);
        wr(2'd0, 6'h21, 32'h00000004);
        rd_chk("R7 p2 cleared", 2'd2, 6'h04, 32'h0);
        check("R6 irq low", {31'b0, irq}, 32'h0);
        pulse(3'b100);
        rd_chk("R5 capture pending", 2'd2, 6'h04, 32'h80000001);
        wr(2'd0, 6'h21, 32'h0);
        rd_chk("R7 capture cleared", 2'd2, 6'h04, 32'h0);

        // R9 paged region, page = 7
        probe("R9 paged write", 1'b1, 6'h34, 1'b1, 12'h734);
        rd_chk("R9 local untouched", 2'd2, 6'h00, 32'hBEEFAB60);
        fwd_rdata = 32'h5A5A1234;
        rd_chk("R9 paged read", 2'd2, 6'h3C, 32'h5A5A1234);
        probe("R9 not paged", 1'b0, 6'h20, 1'b0, 12'h0);
        wr(2'd2, 6'h0C, 32'h0);
        probe("R9 page 0", 1'b0, 6'h30, 1'b1, 12'h030);
        wr(2'd2, 6'h0C, 32'h0000000A);
        probe("R9 page A", 1'b1, 6'h3F, 1'b1, 12'hA3F);

        // R11 response timing
        acc(1'b0, 2'd2, 6'h10, 32'h0, r, v);
        check("R11 read resp", {31'b0, v}, 32'h1);
        acc(1'b1, 2'd2, 6'h10, 32'h0, r, v);
        check("R11 write no resp", {31'b0, v}, 32'h0);

        // R1 reset with irq high
        wr(2'd2, 6'h20, 32'h00000100);
        pulse(3'b001);
        check("R1 irq before reset", {31'b0, irq}, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 act after reset", {29'b0, chan_act}, 32'h0);
        rd_chk("R1 ctl", 2'd2, 6'h00, 32'h0);
        rd_chk("R1 sctl", 2'd2, 6'h20, 32'h0);
        rd_chk("R1 page", 2'd2, 6'h0C, 32'h0);
        rd_chk("R1 status", 2'd2, 6'h04, 32'h0);
        rd_chk("R1 codec", 2'd2, 6'h10, 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule